// File: doc/BRIEF.md
# Cell Frame Serializer

This block takes 53-byte cells from a buffer-side byte stream and sends each one over a narrow synchronous transfer path. The path is either 4 or 8 bits wide and also carries a one-transfer start-of-frame marker. Two strap inputs are captured while reset is held. One sets the lane width. The other sets the pacing: free-running, with one transfer on every system clock, or enable-paced, with one transfer on each cycle where an external advance input is high. Everything runs on a single system clock. Each transfer updates registered outputs, and a transfer-enable output is raised for the one clock in which new values are shown.

The input side does not buffer a whole cell. It pulls cell bytes at the moment the lane order needs them. One hold register is enough for both orders: the upper nibble of each byte goes before its lower nibble in 4-bit lanes, and the two bytes of each 16-bit word are swapped in 8-bit lanes. In 8-bit lanes the odd final byte is paired with a zero pad byte, so the frame is 54 transfers long. A new cell may begin on the last transfer of the current one. Its marker then shares that transfer with the final data.

The controller has three states. IDLE shows zeros. MARK shows the marker. SEND shows data transfers. The transitions are:
- IDLE->MARK: a start-of-cell byte is taken on a transfer step.
- MARK->SEND: the next step.
- SEND->SEND: steps before the final transfer.
- SEND->MARK: the final transfer coincides with the take of a new start-of-cell byte.
- SEND->IDLE: the final transfer passes with no new cell.

Top module: `cell_frame_serializer`

## Requirements
- R1: The lane width (strap_wide 0 = 4-bit, 1 = 8-bit) and the pacing (strap_paced 0 = free-running, 1 = enable-paced) are captured while rst_n is low. Strap changes after reset have no effect.
- R2: In free-running pacing, xfer_en is high on every clock after reset. In enable-paced pacing, xfer_en equals ext_adv of the previous clock. While xfer_en is low, lane_data and lane_mark hold their values.
- R3: lane_mark is high on exactly one transfer per cell: the transfer immediately before the first data transfer of that cell.
- R4: In 4-bit lanes a cell takes 106 data transfers. Byte i appears at transfer 2i as its bits 7:4 and at transfer 2i+1 as its bits 3:0, both on lane_data[3:0], with lane_data[7:4] at zero.
- R5: In 8-bit lanes a cell takes 54 data transfers. Transfer t carries cell byte t XOR 1, and the pad byte 53 (transfer 52) is zero.
- R6: In free-running pacing, the data transfers of a cell fall on consecutive clocks, with the last one exactly 106 (4-bit) or 54 (8-bit) clocks after the marker.
- R7: A start-of-cell byte is taken only in IDLE or on the final transfer of a cell. When the next cell is already waiting, its marker appears on the same transfer as the previous cell's final data.
- R8: Under reset the outputs are zero. After the transfer that follows a cell's final data, lane_data is zero and lane_mark is low until the next marker. A marker that starts from IDLE carries zero data.
- R9: A byte without the start-of-cell flag, presented while IDLE, is consumed (src_ready high) and discarded. It starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while low |
| strap_wide | input | 1 | Lane width strap: 0 = 4-bit, 1 = 8-bit |
| strap_paced | input | 1 | Pacing strap: 0 = free-running, 1 = enable-paced |
| ext_adv | input | 1 | External transfer enable, used in enable-paced pacing |
| src_data | input | 8 | Cell byte from the buffer side |
| src_sof | input | 1 | Marks the first byte of a cell |
| src_valid | input | 1 | src_data and src_sof are valid |
| src_ready | output | 1 | The byte is taken on this clock |
| lane_data | output | 8 | Transfer data; only bits 3:0 are used in 4-bit lanes |
| lane_mark | output | 1 | Start-of-frame marker |
| xfer_en | output | 1 | High on the clock that shows a new transfer |

## Verification
Two events can share one transfer: the final data of a cell and the marker of the next cell. The bench provokes this by queuing two cells back to back, so the second start-of-cell byte is waiting when the first cell reaches its last transfer. This is done in every width and pacing combination, with the advance input driven from a pseudo-random sequence. A monitor judges it by comparing the shared transfer's data against the first cell's arithmetically computed last lane value while also seeing the marker. It then requires the second cell's data to start on the next transfer. A third cell sent after an idle gap checks the opposite path, in which the marker carries zero data.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MARK = 2'd1,
        ST_SEND = 2'd2
    } cfs_state_e;

endpackage

// File: rtl/cfs_mode_latch.sv
module cfs_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_wide,
    input  logic strap_paced,
    output logic mode_wide,
    output logic mode_paced
);

    // Straps are followed only while reset is held (R1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_wide  <= strap_wide;
            mode_paced <= strap_paced;
        end
    end

endmodule

// File: rtl/cfs_xfer_counter.sv
module cfs_xfer_counter #(
    parameter int CELL_BYTES = 53,
    parameter int IDX_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic             wide,
    output logic [IDX_W-1:0] idx,
    output logic             at_last
);

    localparam logic [IDX_W-1:0] LAST_NIB  = IDX_W'(2 * CELL_BYTES - 1);
    localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(CELL_BYTES + (CELL_BYTES % 2) - 1);

    assign at_last = (idx == (wide ? LAST_BYTE : LAST_NIB));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (advance) begin
            idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/cfs_lane_select.sv
module cfs_lane_select #(
    parameter int CELL_BYTES = 53,
    parameter int DATA_W     = 8,
    parameter int IDX_W      = 7
) (
    input  logic              wide,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] hold,
    input  logic [DATA_W-1:0] in_byte,
    output logic [DATA_W-1:0] lane,
    output logic              take,
    output logic              hold_load
);

    localparam int               NIB_W    = DATA_W / 2;
    localparam logic [IDX_W-1:0] CELL_L   = IDX_W'(CELL_BYTES);
    localparam logic [IDX_W-1:0] LAST_NIB = IDX_W'(2 * CELL_BYTES - 1);

    logic [IDX_W-1:0] idx_pair;
    logic [IDX_W-1:0] idx_next;

    assign idx_pair = idx ^ IDX_W'(1);
    assign idx_next = idx + IDX_W'(1);

    always_comb begin
        lane      = '0;
        take      = 1'b0;
        hold_load = 1'b0;
        if (!wide) begin
            // Upper nibble on even transfers, lower on odd ones.
            lane      = {{NIB_W{1'b0}}, idx[0] ? hold[NIB_W-1:0] : hold[DATA_W-1:NIB_W]};
            take      = idx[0] && (idx != LAST_NIB);
            hold_load = take;
        end else if (!idx[0]) begin
            // Even transfer: the higher byte of the pair goes out as it arrives.
            take      = (idx_pair < CELL_L);
            lane      = take ? in_byte : '0;
            hold_load = 1'b0;
        end else begin
            // Odd transfer: the held lower byte goes out, the next one is fetched.
            lane      = hold;
            take      = (idx_next < CELL_L);
            hold_load = take;
        end
    end

endmodule

// File: rtl/cell_frame_serializer.sv
module cell_frame_serializer
    import cfs_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_wide,
    input  logic              strap_paced,
    input  logic              ext_adv,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_sof,
    input  logic              src_valid,
    output logic              src_ready,
    output logic [DATA_W-1:0] lane_data,
    output logic              lane_mark,
    output logic              xfer_en
);

    localparam int IDX_W = $clog2(2 * CELL_BYTES + 1);

    logic              mode_wide;
    logic              mode_paced;
    logic              step;
    cfs_state_e        st;
    cfs_state_e        st_nx;
    logic [IDX_W-1:0]  xfer_idx;
    logic              at_last;
    logic [DATA_W-1:0] lane_nx;
    logic              mid_take;
    logic              hold_load;
    logic [DATA_W-1:0] hold;
    logic              sof_take;
    logic              cnt_adv;

    cfs_mode_latch u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_wide (strap_wide),
        .strap_paced(strap_paced),
        .mode_wide  (mode_wide),
        .mode_paced (mode_paced)
    );

    cfs_xfer_counter #(
        .CELL_BYTES(CELL_BYTES),
        .IDX_W     (IDX_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (sof_take),
        .advance(cnt_adv),
        .wide   (mode_wide),
        .idx    (xfer_idx),
        .at_last(at_last)
    );

    cfs_lane_select #(
        .CELL_BYTES(CELL_BYTES),
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W)
    ) u_lane (
        .wide     (mode_wide),
        .idx      (xfer_idx),
        .hold     (hold),
        .in_byte  (src_data),
        .lane     (lane_nx),
        .take     (mid_take),
        .hold_load(hold_load)
    );

    assign step = mode_paced ? ext_adv : 1'b1;

    // Next state and byte-take decisions.
    always_comb begin
        st_nx     = st;
        src_ready = 1'b0;
        sof_take  = 1'b0;
        cnt_adv   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                src_ready = step;
                if (step && src_valid && src_sof) begin
                    sof_take = 1'b1;
                    st_nx    = ST_MARK;
                end
            end
            ST_MARK: begin
                src_ready = step && mid_take;
                if (step) begin
                    cnt_adv = 1'b1;
                    st_nx   = ST_SEND;
                end
            end
            ST_SEND: begin
                if (step) begin
                    if (at_last) begin
                        src_ready = 1'b1;
                        if (src_valid && src_sof) begin
                            sof_take = 1'b1;
                            st_nx    = ST_MARK;
                        end else begin
                            st_nx = ST_IDLE;
                        end
                    end else begin
                        src_ready = mid_take;
                        cnt_adv   = 1'b1;
                    end
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Output and hold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_data <= '0;
            lane_mark <= 1'b0;
            xfer_en   <= 1'b0;
            hold      <= '0;
        end else begin
            xfer_en <= step;
            if (step) begin
                unique case (st)
                    ST_IDLE:          lane_data <= '0;
                    ST_MARK, ST_SEND: lane_data <= lane_nx;
                    default:          lane_data <= '0;
                endcase
                lane_mark <= sof_take;
                if (sof_take || (hold_load && (st != ST_IDLE))) begin
                    hold <= src_data;
                end
            end
        end
    end

endmodule

// File: rtl/cfs_checker.sv
module cfs_checker
    import cfs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_wide,
    input logic              mode_paced,
    input logic              step,
    input cfs_state_e        st,
    input logic [IDX_W-1:0]  xfer_idx,
    input logic              at_last,
    input logic              src_valid,
    input logic              src_ready,
    input logic              src_sof,
    input logic [DATA_W-1:0] lane_data,
    input logic              lane_mark,
    input logic              xfer_en
);

    a_r1_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(mode_wide) && $stable(mode_paced)));

    a_r2_free_run_en: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_paced |=> xfer_en);

    a_r2_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |-> ($stable(lane_data) && $stable(lane_mark)));

    a_r3_mark_state: assert property (@(posedge clk) disable iff (!rst_n)
        lane_mark |-> (st == ST_MARK));

    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wide |-> (lane_data[DATA_W-1:DATA_W/2] == '0));

    a_r6_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_paced && (st != ST_IDLE) && !at_last) |=>
            (xfer_idx == IDX_W'($past(xfer_idx) + 1'b1)));

    a_r7_sof_window: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready && src_sof) |-> ((st == ST_IDLE) || at_last));

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE) && ($past(st) == ST_IDLE) && $past(step)) |->
            ((lane_data == '0) && !lane_mark));

endmodule

bind cell_frame_serializer cfs_checker #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
) i_cfs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wide (mode_wide),
    .mode_paced(mode_paced),
    .step      (step),
    .st        (st),
    .xfer_idx  (xfer_idx),
    .at_last   (at_last),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .src_sof   (src_sof),
    .lane_data (lane_data),
    .lane_mark (lane_mark),
    .xfer_en   (xfer_en)
);

// File: tb/test_cell_frame_serializer.sv
module test_cell_frame_serializer;

    localparam int CB = 53;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_wide = 1'b0;
    logic       strap_paced = 1'b0;
    logic       ext_adv = 1'b0;
    logic [7:0] src_data;
    logic       src_sof;
    logic       src_valid;
    logic       src_ready;
    logic [7:0] lane_data;
    logic       lane_mark;
    logic       xfer_en;

    always #4 clk = ~clk;

    cell_frame_serializer i_cell_frame_serializer (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_wide (strap_wide),
        .strap_paced(strap_paced),
        .ext_adv    (ext_adv),
        .src_data   (src_data),
        .src_sof    (src_sof),
        .src_valid  (src_valid),
        .src_ready  (src_ready),
        .lane_data  (lane_data),
        .lane_mark  (lane_mark),
        .xfer_en    (xfer_en)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Byte source queue.
    logic [7:0] item_d [0:255];
    logic       item_s [0:255];
    int         n_items = 0;
    int         pos = 0;

    assign src_valid = (pos < n_items);
    assign src_data  = item_d[pos];
    assign src_sof   = item_s[pos];

    always @(posedge clk) begin
        if (!rst_n) pos <= 0;
        else if (src_valid && src_ready) pos <= pos + 1;
    end

    // Advance pattern (ignored in free-running pacing).
    logic [7:0] lfsr = 8'h5B;
    logic       adv_q = 1'b0;
    always @(negedge clk) begin
        lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        ext_adv <= lfsr[0] | lfsr[2];
    end
    always @(posedge clk) adv_q <= ext_adv;

    int cfg_id = 0;
    bit cfg_wide = 1'b0;
    bit cfg_paced = 1'b0;

    function automatic logic [7:0] byte_val(int cfg, int c, int i);
        return 8'((((c + 1) * 29) + i * 13 + cfg * 71) & 255);
    endfunction

    // R4 / R5 lane order computed from the requirement text.
    function automatic logic [7:0] exp_lane(int cfg, int c, int t, bit wide);
        logic [7:0] b;
        int idx;
        if (!wide) begin
            b = byte_val(cfg, c, t / 2);
            return (t % 2 == 0) ? {4'h0, b[7:4]} : {4'h0, b[3:0]};
        end
        idx = t ^ 1;
        if (idx >= CB) return 8'h00;
        return byte_val(cfg, c, idx);
    endfunction

    task automatic push_item(logic [7:0] d, logic s);
        item_d[n_items] = d;
        item_s[n_items] = s;
        n_items = n_items + 1;
    endtask

    task automatic push_cell(int c);
        for (int i = 0; i < CB; i++) push_item(byte_val(cfg_id, c, i), (i == 0));
    endtask

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Monitor.
    bit mon_on = 1'b0;
    bit in_cell = 1'b0;
    int t_exp = 0, cur_cell = 0, next_cell = 0, cells_done = 0;
    int mism = 0, frame_bad = 0, idle_bad = 0, en_bad = 0, quiet_bad = 0;
    int stall_bad = 0, overlap_seen = 0, cyc = 0, mark_cyc = 0;
    logic [7:0] prev_data = 8'h00;
    logic       prev_mark = 1'b0;

    always @(negedge clk) begin
        int count;
        cyc = cyc + 1;
        count = cfg_wide ? (CB + CB % 2) : 2 * CB;
        if (mon_on) begin
            if (!cfg_paced) begin
                if (xfer_en !== 1'b1) en_bad++;
            end else if (xfer_en !== adv_q) en_bad++;
            if (!xfer_en && (lane_data !== prev_data || lane_mark !== prev_mark)) quiet_bad++;
            if (xfer_en) begin
                if (in_cell) begin
                    if (lane_data !== exp_lane(cfg_id, cur_cell, t_exp, cfg_wide)) mism++;
                    if (lane_mark && t_exp != count - 1) frame_bad++;
                    t_exp++;
                    if (t_exp == count) begin
                        in_cell = 1'b0;
                        cells_done++;
                        if (!cfg_paced && (cyc - mark_cyc) != count) stall_bad++;
                        if (lane_mark) overlap_seen++;
                    end
                end else if (lane_data !== 8'h00) begin
                    idle_bad++;
                end
                if (lane_mark) begin
                    in_cell  = 1'b1;
                    t_exp    = 0;
                    cur_cell = next_cell;
                    next_cell++;
                    mark_cyc = cyc;
                end
            end
        end
        prev_data = lane_data;
        prev_mark = lane_mark;
    end

    // Watchdog.
    always @(negedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_cells(int n, string req);
        int w = 0;
        while (cells_done < n && w < 5000) begin
            @(negedge clk);
            w++;
        end
        check(cells_done >= n, req, cells_done, n);
    endtask

    task automatic run_config(int cfg);
        string data_req;
        cfg_id    = cfg;
        cfg_wide  = cfg[0];
        cfg_paced = cfg[1];
        data_req  = cfg_wide ? "R5 byte-swapped lanes" : "R4 nibble lanes";
        mon_on = 1'b0;
        rst_n = 1'b0;
        strap_wide  = cfg_wide;
        strap_paced = cfg_paced;
        n_items = 0;
        in_cell = 1'b0;
        next_cell = 0; cells_done = 0; mism = 0; frame_bad = 0; idle_bad = 0;
        en_bad = 0; quiet_bad = 0; stall_bad = 0; overlap_seen = 0;
        repeat (4) @(negedge clk);
        check(lane_data == 8'h00 && !lane_mark && !xfer_en, "R8 reset outputs",
              {lane_data, lane_mark, xfer_en}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: straps flipped after reset must change nothing.
        strap_wide  = ~cfg_wide;
        strap_paced = ~cfg_paced;
        mon_on = 1'b1;
        repeat (6) @(negedge clk);
        check(lane_data == 8'h00 && !lane_mark, "R8 idle outputs", {lane_data, lane_mark}, 0);
        // R9: stray byte without start flag, then two back-to-back cells (R7).
        push_item(8'hA5, 1'b0);
        push_cell(0);
        push_cell(1);
        wait_cells(2, "R7 back-to-back delivery");
        repeat (20) @(negedge clk);
        push_cell(2);
        wait_cells(3, "R8 cell after idle gap");
        repeat (30) @(negedge clk);
        mon_on = 1'b0;
        @(negedge clk);
        check(cells_done == 3, "R9 stray byte discarded", cells_done, 3);
        check(mism == 0, data_req, mism, 0);
        check(mism == 0 && en_bad == 0, "R1 straps frozen after reset", mism + en_bad, 0);
        check(frame_bad == 0, "R3 marker placement", frame_bad, 0);
        check(overlap_seen == 1, "R7 marker on final data", overlap_seen, 1);
        check(en_bad == 0, "R2 transfer enable", en_bad, 0);
        check(quiet_bad == 0, "R2 outputs hold without enable", quiet_bad, 0);
        check(idle_bad == 0, "R8 idle zero", idle_bad, 0);
        check(pos == n_items, "R9 all bytes consumed", pos, n_items);
        if (!cfg_paced) check(stall_bad == 0, "R6 no stall", stall_bad, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            item_d[i] = 8'h00;
            item_s[i] = 1'b0;
        end
        for (int cfg = 0; cfg < 4; cfg++) run_config(cfg);
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule